// File: doc/BRIEF.md
# Time-Slot Interchange Switching Core

This core moves bytes between serial-stream time slots at the byte level. It has `NS` input streams and `NS` output streams, and each stream carries `NCH` eight-bit channels per frame. One clock cycle is one time slot, and all streams deliver one byte in each cycle. Every received byte is stored in a data memory that holds three frames. Each output channel has one 16-bit connection word that says what that output slot carries: a byte switched from any input stream and channel, or a byte taken straight from the connection word itself.

Each connection word also selects the delay mode for its channel, either lowest latency (variable) or frame-preserving (constant). The same word holds an output-enable bit, a control bit that appears beside the data, and a loopback bit that writes the transmitted byte back into the receive path. A synchronous port lets a processor write and read connection words and read the stored input bytes.

The counters start at slot 0 of frame 0 in the first cycle after reset. Slot bits, line coding and frame-pulse handling belong to the surrounding serial interface logic.

Top module: `tsi_core`

## Requirements
- R1: During reset, and in the first slot after reset, `tx_data`, `tx_oe` and `ctl_out` are all zero. Reset also clears every connection word to zero.
- R2: The slot counter steps once per clock and wraps after `NCH` slots, and each wrap starts a new frame. In every slot the byte on `rx_data[8s+7:8s]` is taken as channel `slot` of stream `s`.
- R3: Connection word fields are: bit 15 loopback, bit 14 constant delay, bit 13 processor data, bit 12 control bit, bit 11 output enable, bit 10 reserved, bits 9..7 source stream, bits 6..0 source channel. With bits 13 and 14 clear, a byte received in slot n appears on output slot m after d slots. Here d = (m-n) mod NCH, and NCH is added when that value is below 3.
- R4: With bit 14 set and bit 13 clear, a byte received in slot n of frame k appears in slot m of frame k+2, which is 2·NCH+m-n slots later.
- R5: With bit 13 set, the output slot carries bits 7..0 of its connection word in every frame.
- R6: `tx_oe[s]` is 0 when `ode` and `standby` are both 0. Otherwise it equals bit 11 of the word in force for the current slot of stream s.
- R7: Any number of output channels may name the same source, and each of them carries that source byte with its own delay.
- R8: When `cpu_en` and `cpu_we` are high, `cpu_wdata` is written to the connection word at (`cpu_stream`, `cpu_chan`), whatever the value of `cpu_dm`. A read with `cpu_dm`=0 returns that word on `cpu_rdata` one cycle later. While no read is issued, `cpu_rdata` holds its value.
- R9: A read with `cpu_dm`=1 returns, in the low byte, the byte stored for (`cpu_stream`, `cpu_chan`) in the previous frame, with the high byte zero. The result is valid when the read is issued in any slot except slot 0.
- R10: With bit 15 set, the byte transmitted on stream s in slot m is stored as input channel m of stream s in place of `rx_data`.
- R11: `ctl_out[s]` carries bit 12 of the word in force for the current slot of stream s.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot clock, one time slot per cycle |
| rst | input | 1 | Synchronous reset, active high |
| rx_data | input | NS*8 | Received byte of each stream for the current slot |
| tx_data | output | NS*8 | Transmitted byte of each stream for the current slot |
| tx_oe | output | NS | Per-stream drive enable for the current slot |
| ctl_out | output | NS | Per-stream control bit for the current slot |
| ode | input | 1 | Global output drive enable |
| standby | input | 1 | Standby bit, enables outputs when `ode` is low |
| cpu_en | input | 1 | Processor access strobe |
| cpu_we | input | 1 | 1 = write connection word, 0 = read |
| cpu_dm | input | 1 | Read target: 1 = data memory, 0 = connection memory |
| cpu_stream | input | 3 | Stream selected for the access |
| cpu_chan | input | 7 | Channel selected for the access |
| cpu_wdata | input | 16 | Connection word to write |
| cpu_rdata | output | 16 | Read result, one cycle after the read |

## Verification
The bench targets the frame seam, where the variable-delay bank choice is easiest to get wrong. A source that is up to two slots ahead of its output must wait a whole frame, and near the end of a frame it must reach back two frames. A core that picked the wrong bank would send a byte one frame stale or one frame early, and every offset sweep would show it. Constant delay is swept over all channel offsets; a bank rotation off by one would give a delay of one or three frames. The remaining tests cover the output-enable gating combinations, loopback replacing the stored input, processor writes made with the data-memory select high, and data-memory reads that would return the current frame if the bank choice were wrong.

// File: rtl/tsi_core.sv
module tsi_core #(
  parameter int NS  = 8,
  parameter int NCH = 128
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NS*8-1:0] rx_data,
  output logic [NS*8-1:0] tx_data,
  output logic [NS-1:0]   tx_oe,
  output logic [NS-1:0]   ctl_out,
  input  logic            ode,
  input  logic            standby,
  input  logic            cpu_en,
  input  logic            cpu_we,
  input  logic            cpu_dm,
  input  logic [2:0]      cpu_stream,
  input  logic [6:0]      cpu_chan,
  input  logic [15:0]     cpu_wdata,
  output logic [15:0]     cpu_rdata
);
  localparam int CW = $clog2(NCH);
  localparam int SW = $clog2(NS);

  function automatic logic [1:0] sub3(input logic [1:0] a, input logic [1:0] b);
    return (a >= b) ? a - b : a + 2'd3 - b;
  endfunction

  logic [CW-1:0]   chan, wchan, tchan;
  logic [1:0]      fb, wbank, fb_nx, tbank;
  logic            wvld, last;
  logic [NS*8-1:0] rx_q, tx_q, fetch, f_low;
  logic [NS-1:0]   f_proc, f_oe, f_lb, f_ctl, oe_q, lb_q, ctl_q;
  logic [7:0]      dmem [3][NS][NCH];
  logic [15:0]     cmem [NS][NCH];
  logic [SW-1:0]   cs;
  logic [CW-1:0]   cc;

  assign last  = chan == CW'(NCH - 1);
  assign tchan = chan + 1'b1;
  assign fb_nx = (fb == 2'd2) ? 2'd0 : fb + 2'd1;
  assign tbank = last ? fb_nx : fb;
  assign cs    = cpu_stream[SW-1:0];
  assign cc    = cpu_chan[CW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      chan  <= '0;
      fb    <= '0;
      wvld  <= 1'b0;
      wchan <= '0;
      wbank <= '0;
    end else begin
      chan  <= tchan;
      if (last) fb <= fb_nx;
      wvld  <= 1'b1;
      wchan <= chan;
      wbank <= fb;
    end
  end

  for (genvar s = 0; s < NS; s++) begin : g_st
    logic [SW-1:0] ss;
    logic [CW-1:0] n, diff;
    logic [1:0]    back, bank;
    assign ss   = cmem[s][tchan][7 +: SW];
    assign n    = cmem[s][tchan][CW-1:0];
    assign diff = tchan - n;
    assign back = cmem[s][tchan][14] ? 2'd2
                : {1'b0, tchan < n} + {1'b0, diff < CW'(3)};
    assign bank = sub3(tbank, back);
    assign f_low[s*8 +: 8] = cmem[s][tchan][7:0];
    assign f_proc[s] = cmem[s][tchan][13];
    assign f_oe[s]   = cmem[s][tchan][11];
    assign f_lb[s]   = cmem[s][tchan][15];
    assign f_ctl[s]  = cmem[s][tchan][12];
    assign fetch[s*8 +: 8] = f_proc[s] ? f_low[s*8 +: 8] : dmem[bank][ss][n];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_q  <= '0;
      oe_q  <= '0;
      lb_q  <= '0;
      ctl_q <= '0;
    end else begin
      tx_q  <= fetch;
      oe_q  <= f_oe;
      lb_q  <= f_lb;
      ctl_q <= f_ctl;
    end
  end

  always_ff @(posedge clk) begin
    for (int s = 0; s < NS; s++) begin
      rx_q[s*8 +: 8] <= lb_q[s] ? tx_q[s*8 +: 8] : rx_data[s*8 +: 8];
      if (wvld) dmem[wbank][s][wchan] <= rx_q[s*8 +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < NS; s++)
        for (int c = 0; c < NCH; c++)
          cmem[s][c] <= '0;
    end else if (cpu_en && cpu_we) begin
      cmem[cs][cc] <= cpu_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cpu_rdata <= '0;
    else if (cpu_en && !cpu_we)
      cpu_rdata <= cpu_dm ? {8'h00, dmem[sub3(fb, 2'd1)][cs][cc]} : cmem[cs][cc];
  end

  assign tx_data = tx_q;
  assign tx_oe   = oe_q & {NS{ode | standby}};
  assign ctl_out = ctl_q;
endmodule

// File: rtl/tsi_core_chk.sv
module tsi_core_chk #(
  parameter int NCH = 128
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   ode,
  input logic                   standby,
  input logic                   tx_oe_any,
  input logic [7:0]             tx0,
  input logic                   proc0,
  input logic [7:0]             low0,
  input logic                   fetch_oe0,
  input logic                   oe_reg0,
  input logic [$clog2(NCH)-1:0] chan,
  input logic [1:0]             fb,
  input logic                   cpu_en,
  input logic                   cpu_we,
  input logic                   cpu_dm,
  input logic [15:0]            cpu_rdata
);
  AST_GLOBAL_HIZ: assert property (@(posedge clk) disable iff (rst)
    (!ode && !standby) |-> !tx_oe_any); // R6
  AST_OE_SET: assert property (@(posedge clk) disable iff (rst)
    fetch_oe0 |=> oe_reg0); // R6
  AST_OE_CLR: assert property (@(posedge clk) disable iff (rst)
    !fetch_oe0 |=> !oe_reg0); // R6
  AST_PROC_BYTE: assert property (@(posedge clk) disable iff (rst)
    proc0 |=> (tx0 == $past(low0))); // R5
  AST_FRAME_WRAP: assert property (@(posedge clk) disable iff (rst)
    (chan == $clog2(NCH)'(NCH - 1)) |=> (chan == '0 && fb != $past(fb))); // R2
  AST_DM_HIGH_ZERO: assert property (@(posedge clk) disable iff (rst)
    (cpu_en && !cpu_we && cpu_dm) |=> (cpu_rdata[15:8] == 8'h00)); // R9
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(cpu_en && !cpu_we) |=> $stable(cpu_rdata)); // R8
endmodule

bind tsi_core tsi_core_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst(rst), .ode(ode), .standby(standby),
  .tx_oe_any(|tx_oe), .tx0(tx_data[7:0]), .proc0(f_proc[0]), .low0(f_low[7:0]),
  .fetch_oe0(f_oe[0]), .oe_reg0(oe_q[0]), .chan(chan), .fb(fb),
  .cpu_en(cpu_en), .cpu_we(cpu_we), .cpu_dm(cpu_dm), .cpu_rdata(cpu_rdata)
);

// File: tb/tb_tsi_core.sv
`timescale 1ns/1ps
module tb_tsi_core;
  localparam int NS = 2, NCH = 8;

  logic clk = 0, rst = 1;
  always #2.5 clk = ~clk;

  logic [NS*8-1:0] rx_data = '0;
  logic [NS*8-1:0] tx_data;
  logic [NS-1:0]   tx_oe, ctl_out;
  logic ode = 1, standby = 0;
  logic cpu_en = 0, cpu_we = 0, cpu_dm = 0;
  logic [2:0] cpu_stream = 0;
  logic [6:0] cpu_chan = 0;
  logic [15:0] cpu_wdata = 0;
  logic [15:0] cpu_rdata;

  tsi_core #(.NS(NS), .NCH(NCH)) dut (
    .clk(clk), .rst(rst), .rx_data(rx_data), .tx_data(tx_data), .tx_oe(tx_oe),
    .ctl_out(ctl_out), .ode(ode), .standby(standby), .cpu_en(cpu_en),
    .cpu_we(cpu_we), .cpu_dm(cpu_dm), .cpu_stream(cpu_stream), .cpu_chan(cpu_chan),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata));

  int total = 0, bad = 0, slot_k = 0;
  bit chk = 0, bcast = 0, lbt = 0;
  logic [15:0] cfg [NS][NCH];
  logic [15:0] nxt [NS][NCH];

  function automatic logic [7:0] byte_of(int s, int g, int n);
    return 8'(g * 37 + s * 101 + n * 13 + 7);
  endfunction

  function automatic logic [7:0] src_byte(int s, int g, int n);
    if (cfg[s][n][15]) return cfg[s][n][7:0];
    return byte_of(s, g, n);
  endfunction

  function automatic logic [15:0] sw_word(bit cst, bit ctl, bit oe, int ss, int n);
    return {1'b0, cst, 1'b0, ctl, oe, 1'b0, 3'(ss), 7'(n)};
  endfunction

  function automatic logic [15:0] pr_word(bit lb, bit ctl, bit oe, logic [7:0] d);
    return {lb, 1'b0, 1'b1, ctl, oe, 3'b000, d};
  endfunction

  task automatic check(string r, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h slot=%0d", r, act, exp, slot_k);
    end
  endtask

  always @(negedge clk) begin
    if (rst) slot_k = 0;
    else begin
      if (slot_k == 0) begin
        check("R1 tx_data", 16'(tx_data), 16'h0);
        check("R1 tx_oe", 16'(tx_oe), 16'h0);
        check("R1 ctl_out", 16'(ctl_out), 16'h0);
      end
      if (chk) begin
        for (int s = 0; s < NS; s++) begin
          int m, d, src;
          logic [15:0] w;
          logic [7:0] e;
          string tg;
          m = slot_k % NCH;
          w = cfg[s][m];
          if (w[13]) begin
            e = w[7:0]; tg = "R5";
          end else begin
            int ss, n;
            ss = w[9:7]; n = w[6:0];
            if (w[14]) begin
              d = 2 * NCH + m - n; tg = "R4";
            end else begin
              d = ((m - n) % NCH + NCH) % NCH;
              if (d < 3) d += NCH;
              tg = "R3 (R2 slot timing)";
            end
            src = slot_k - d;
            e = src_byte(ss, src / NCH, src % NCH);
          end
          if (bcast) tg = "R7";
          if (lbt) tg = "R10";
          check(tg, 16'(tx_data[s*8 +: 8]), 16'(e));
          check("R6", 16'(tx_oe[s]), 16'(w[11] & (ode | standby)));
          check("R11", 16'(ctl_out[s]), 16'(w[12]));
        end
      end
      for (int s = 0; s < NS; s++)
        rx_data[s*8 +: 8] = byte_of(s, slot_k / NCH, slot_k % NCH);
      slot_k++;
    end
  end

  task automatic tick();
    @(negedge clk); #1;
  endtask

  task automatic cpu_wr(int s, int c, logic [15:0] w, bit dm);
    tick();
    cpu_en = 1; cpu_we = 1; cpu_dm = dm; cpu_stream = 3'(s); cpu_chan = 7'(c); cpu_wdata = w;
    cfg[s][c] = w;
    tick();
    cpu_en = 0; cpu_we = 0; cpu_dm = 0;
  endtask

  task automatic cpu_rd(int s, int c, bit dm, output logic [15:0] d, output int cur);
    tick();
    while ((slot_k - 1) % NCH == 0) tick();
    cur = slot_k - 1;
    cpu_en = 1; cpu_we = 0; cpu_dm = dm; cpu_stream = 3'(s); cpu_chan = 7'(c);
    tick();
    cpu_en = 0; cpu_dm = 0;
    d = cpu_rdata;
  endtask

  task automatic commit();
    chk = 0;
    for (int s = 0; s < NS; s++)
      for (int m = 0; m < NCH; m++)
        cpu_wr(s, m, nxt[s][m], 0);
    repeat (3 * NCH + 2) tick();
    chk = 1;
    repeat (2 * NCH) tick();
    chk = 0;
  endtask

  initial begin
    logic [15:0] rd;
    int cur;
    repeat (3) @(posedge clk);
    #1 rst = 0;
    for (int s = 0; s < NS; s++)
      for (int m = 0; m < NCH; m++) cfg[s][m] = '0;
    // R1: connection words cleared by reset
    cpu_rd(1, 5, 0, rd, cur);
    check("R1 cm clear", rd, 16'h0);

    // R3: variable delay, every channel offset
    for (int k = 0; k < NCH; k++) begin
      for (int s = 0; s < NS; s++)
        for (int m = 0; m < NCH; m++)
          nxt[s][m] = sw_word(0, 0, 1, (s + 1) % NS, (m + k) % NCH);
      commit();
    end
    // R4: constant delay, every channel offset
    for (int k = 0; k < NCH; k++) begin
      for (int s = 0; s < NS; s++)
        for (int m = 0; m < NCH; m++)
          nxt[s][m] = sw_word(1, 0, 1, (s + k) % NS, (m + 3 * k) % NCH);
      commit();
    end
    // R5, R11: mixed modes per channel
    for (int s = 0; s < NS; s++)
      for (int m = 0; m < NCH; m++)
        case ((s + m) % 3)
          0: nxt[s][m] = pr_word(0, m[0], 1, 8'(m * 17 + s * 3 + 1));
          1: nxt[s][m] = sw_word(0, m[0], 1, s, (m + 5) % NCH);
          default: nxt[s][m] = sw_word(1, ~m[0], 1, 1 - s, m);
        endcase
    commit();
    // R7: one source broadcast to all outputs, both delay modes
    bcast = 1;
    for (int s = 0; s < NS; s++)
      for (int m = 0; m < NCH; m++) nxt[s][m] = sw_word(0, 0, 1, 0, 5);
    commit();
    for (int s = 0; s < NS; s++)
      for (int m = 0; m < NCH; m++) nxt[s][m] = sw_word(1, 1, 1, 1, 2);
    commit();
    bcast = 0;
    // R9: data memory reads return previous frame
    for (int s = 0; s < NS; s++)
      for (int c = 0; c < NCH; c += 3) begin
        cpu_rd(s, c, 1, rd, cur);
        check("R9", rd, {8'h00, byte_of(s, cur / NCH - 1, c)});
      end
    // R8: write with data select high lands in connection memory; read holds
    cpu_wr(1, 6, 16'h5A3C, 1);
    cpu_rd(1, 6, 0, rd, cur);
    check("R8 readback", rd, 16'h5A3C);
    tick(); tick();
    check("R8 hold", cpu_rdata, 16'h5A3C);
    cpu_wr(0, 2, 16'hC3A5, 0);
    cpu_rd(0, 2, 0, rd, cur);
    check("R8 readback", rd, 16'hC3A5);
    // R6: enable gating over all ode/standby combinations
    for (int s = 0; s < NS; s++)
      for (int m = 0; m < NCH; m++)
        nxt[s][m] = sw_word(0, 0, (s + m) % 2, 1 - s, (m + 4) % NCH);
    commit();
    for (int v = 0; v < 4; v++) begin
      chk = 0; tick();
      ode = v[0]; standby = v[1];
      chk = 1;
      repeat (NCH + 1) tick();
    end
    chk = 0; ode = 1; standby = 0;
    // R10: loopback on stream 0 feeds stream 1 through the data memory
    lbt = 1;
    for (int m = 0; m < NCH; m++) begin
      nxt[0][m] = pr_word(1, 0, 1, 8'hA0 + 8'(m));
      nxt[1][m] = sw_word(m[0], 0, 1, 0, (m + 4) % NCH);
    end
    commit();
    lbt = 0;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule